// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Chain

This block connects a row of peripheral interrupt sources to one processor. All sources share one request line. The processor answers that line with a single acknowledge signal, which passes serially from node to node. A node that has a request outstanding when the acknowledge reaches it keeps it and stops it there. A node with nothing outstanding passes the acknowledge on to the next node. The node that keeps the acknowledge drives its own vector-table entry address onto a shared bus and raises a valid strobe. No central encoder is used. Priority comes from position in the chain: node 0, nearest the processor, wins over every node behind it.

A device asks for service by pulsing its raise input, which sets a pending bit in its node. When the acknowledge rises, each node takes a snapshot of its pending bit. The chain resolves on those snapshots, so a request that arrives while the acknowledge is high cannot split the chain. The processor reads the vector and pulses accept. The granted node then clears its pending bit on the next edge. The processor must bring the acknowledge low for at least one clock edge before it raises it again. If the acknowledge runs off the end of the chain with no node claiming it, a spurious flag is raised.

Top module: `irq_chain_top`

## Requirements
- R1: After reset all outputs are zero. irq_o is high exactly when at least one node has a pending bit set. A one-cycle pulse on raise_i[i] sets that node's pending bit at the next clock edge.
- R2: While ack_i stays high, grant_o is one-hot on the lowest-index node that was pending at the first edge where ack_i was sampled high. The grant is visible in the cycle after that edge.
- R3: While node i is granted, vec_o equals VEC_BASE + i*VEC_STRIDE and vec_valid_o is 1. The defaults are 8'h40 + 4*i.
- R4: When no node is granted, vec_o is zero and vec_valid_o is 0.
- R5: A raise pulse that arrives while ack_i is already high does not change grant_o or vec_o for the rest of that acknowledge. It still sets the pending bit.
- R6: A cycle with accept_i high and node i granted clears pending bit i at that edge. Other pending bits stay set. accept_i with no grant has no effect.
- R7: spurious_o is high when the acknowledge is live and no node was pending at its rising edge. Its grant_o is then zero.
- R8: At most one bit of grant_o is ever high.
- R9: While ack_i is low, grant_o, vec_valid_o and spurious_o are all 0 in that same cycle. A new acknowledge resolves only after ack_i has been low at one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| raise_i | input | N_DEV | Per-device request pulse; sets that node's pending bit |
| ack_i | input | 1 | Acknowledge from the processor into node 0 |
| accept_i | input | 1 | Processor has taken the vector; clears the granted pending bit |
| irq_o | output | 1 | Shared request line, OR of all pending bits |
| grant_o | output | N_DEV | Node currently keeping the acknowledge (one-hot or zero) |
| vec_o | output | VEC_W | Vector-table entry address of the granted node |
| vec_valid_o | output | 1 | vec_o holds a vector |
| spurious_o | output | 1 | Acknowledge passed the last node unclaimed |

## Verification
A raise pulse shows on irq_o one edge later. A rising acknowledge produces its grant, vector and spurious flag one edge after ack_i is first sampled high, because of the snapshot register. An accept clears the pending bit at the edge on which it is seen. Dropping ack_i clears the bus outputs in the same cycle. The bench drives inputs on the falling edge, lets exactly the number of rising edges named above pass, and reads outputs on the following falling edge. The one exception is the same-cycle drop, which it reads a nanosecond after driving. It sweeps every pending pattern of a four-node chain and drains each one with a priority model, so every grant order is compared against the lowest-set-bit rule.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  function automatic int unsigned vec_slot(input int unsigned base,
                                           input int unsigned stride,
                                           input int unsigned idx);
    return base + idx * stride;
  endfunction
endpackage

// File: rtl/irq_ack_track.sv
module irq_ack_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic rise_o,
  output logic live_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= ack_i;
  end

  assign rise_o = ack_i & ~ack_q;
  // live only once the snapshot taken on the rise is in place
  assign live_o = ack_i & ack_q;
endmodule

// File: rtl/irq_node.sv
module irq_node (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raise_i,
  input  logic ack_rise_i,
  input  logic ack_in_i,
  input  logic accept_i,
  output logic pend_o,
  output logic grant_o,
  output logic ack_out_o
);
  logic pend_q, snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      snap_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~(grant_o & accept_i)) | raise_i;
      if (ack_rise_i) snap_q <= pend_q;
    end
  end

  assign pend_o    = pend_q;
  assign grant_o   = ack_in_i & snap_q;
  assign ack_out_o = ack_in_i & ~snap_q;
endmodule

// File: rtl/irq_bus_mux.sv
module irq_bus_mux #(
  parameter int N_DEV = 4,
  parameter int VEC_W = 8
) (
  input  logic [N_DEV-1:0]       grant_i,
  input  logic [N_DEV*VEC_W-1:0] vec_tab_i,
  output logic [VEC_W-1:0]       vec_o,
  output logic                   valid_o
);
  always_comb begin
    vec_o = '0;
    for (int i = 0; i < N_DEV; i++)
      vec_o |= vec_tab_i[i*VEC_W +: VEC_W] & {VEC_W{grant_i[i]}};
  end

  assign valid_o = |grant_i;
endmodule

// File: rtl/irq_chain_top.sv
module irq_chain_top #(
  parameter int N_DEV      = 4,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 64,
  parameter int VEC_STRIDE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] raise_i,
  input  logic             ack_i,
  input  logic             accept_i,
  output logic             irq_o,
  output logic [N_DEV-1:0] grant_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o,
  output logic             spurious_o
);
  import irq_chain_pkg::*;

  localparam int TAB_W = N_DEV * VEC_W;

  logic             ack_rise, ack_live;
  logic [N_DEV:0]   ack_link;
  logic [N_DEV-1:0] pend;
  logic [TAB_W-1:0] vec_tab;

  irq_ack_track u_ack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ack_i (ack_i),
    .rise_o(ack_rise),
    .live_o(ack_live)
  );

  assign ack_link[0] = ack_live;

  for (genvar i = 0; i < N_DEV; i++) begin : g_node
    localparam int unsigned SLOT = vec_slot(VEC_BASE, VEC_STRIDE, i);
    assign vec_tab[i*VEC_W +: VEC_W] = SLOT[VEC_W-1:0];

    irq_node u_node (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .raise_i   (raise_i[i]),
      .ack_rise_i(ack_rise),
      .ack_in_i  (ack_link[i]),
      .accept_i  (accept_i),
      .pend_o    (pend[i]),
      .grant_o   (grant_o[i]),
      .ack_out_o (ack_link[i+1])
    );
  end

  irq_bus_mux #(.N_DEV(N_DEV), .VEC_W(VEC_W)) u_mux (
    .grant_i  (grant_o),
    .vec_tab_i(vec_tab),
    .vec_o    (vec_o),
    .valid_o  (vec_valid_o)
  );

  assign irq_o      = |pend;
  assign spurious_o = ack_link[N_DEV];
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int N_DEV = 4,
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             irq_o,
  input logic [N_DEV-1:0] grant_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_valid_o,
  input logic             spurious_o
);
  p_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  p_idle_bus_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == '0) |-> (vec_o == '0 && !vec_valid_o));

  p_spurious_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spurious_o |-> (grant_o == '0 && ack_i));

  p_ack_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |-> (grant_o == '0 && !vec_valid_o && !spurious_o));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && $past(ack_i) && $past(grant_o) != '0) |-> (grant_o == $past(grant_o)));

  p_grant_from_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_valid_o) |-> $past(irq_o));
endmodule

bind irq_chain_top irq_chain_chk #(.N_DEV(N_DEV), .VEC_W(VEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_i      (ack_i),
  .irq_o      (irq_o),
  .grant_o    (grant_o),
  .vec_o      (vec_o),
  .vec_valid_o(vec_valid_o),
  .spurious_o (spurious_o)
);

// File: tb/irq_chain_top_test.sv
module irq_chain_top_test;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] raise = '0;
  logic         ack = 1'b0;
  logic         accept = 1'b0;
  logic         irq;
  logic [N-1:0] grant;
  logic [W-1:0] vec;
  logic         vvalid;
  logic         spur;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [N-1:0] model = '0;

  always #2 clk = ~clk;

  irq_chain_top uut (
    .clk_i(clk), .rst_ni(rst_n), .raise_i(raise), .ack_i(ack), .accept_i(accept),
    .irq_o(irq), .grant_o(grant), .vec_o(vec), .vec_valid_o(vvalid), .spurious_o(spur)
  );

  function automatic logic [N-1:0] lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic logic [W-1:0] exp_vec(input logic [N-1:0] g);
    for (int i = 0; i < N; i++) if (g[i]) return W'(8'h40 + 4 * i);
    return '0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // grant, vector, valid and spurious for an expected grant g
  task automatic chk_bus(input string req, input logic [N-1:0] g, input logic sp);
    chk({req, " grant"}, 32'(grant), 32'(g));
    chk({"R3 vec"}, 32'(vec), 32'(exp_vec(g)));
    chk({"R4 valid"}, 32'(vvalid), 32'(g != '0));
    chk({"R7 spurious"}, 32'(spur), 32'(sp));
  endtask

  // one acknowledge: ack rises, grant checked, accepted, ack drops
  task automatic serve_one();
    logic [N-1:0] g;
    @(negedge clk) ack = 1'b1;
    @(negedge clk);
    g = lowest(model);
    chk_bus("R2 drain", g, 1'b0);
    accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
    ack = 1'b0;
    model &= ~g;
    chk("R6 irq after accept", 32'(irq), 32'(model != '0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset irq", 32'(irq), 0);
    chk("R1 reset grant", 32'(grant), 0);
    chk("R1 reset vec", 32'(vec), 0);
    chk("R1 reset spurious", 32'(spur), 0);
    rst_n = 1'b1;

    for (int p = 0; p < (1 << N); p++) begin
      logic [N-1:0] g;
      @(negedge clk) raise = N'(p);
      @(negedge clk) raise = '0;
      model |= N'(p);
      chk("R1 irq", 32'(irq), 32'(model != '0));

      ack = 1'b1;
      @(negedge clk);
      g = lowest(model);
      chk_bus("R2", g, model == '0);
      raise = '1;                       // late request mid-acknowledge
      if (g == '0) accept = 1'b1;       // accept with nothing granted
      @(negedge clk);
      raise = '0;
      accept = 1'b0;
      chk("R5 grant held", 32'(grant), 32'(g));
      chk("R5 vec held", 32'(vec), 32'(exp_vec(g)));
      model = '1;
      chk("R1 irq late", 32'(irq), 1);

      if (g != '0) begin
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
        model &= ~g;
      end
      ack = 1'b0;
      #1;
      chk("R9 grant low", 32'(grant), 0);
      chk("R9 valid low", 32'(vvalid), 0);
      chk("R9 spurious low", 32'(spur), 0);

      while (model != '0) serve_one();
      chk("R6 drained irq", 32'(irq), 0);

      // empty chain gives a spurious acknowledge
      @(negedge clk) ack = 1'b1;
      @(negedge clk);
      chk_bus("R7 empty", '0, 1'b1);
      ack = 1'b0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule